// File: doc/BRIEF.md
# Partitioned Buffer Slot Allocator

This block keeps the bookkeeping for a small pool of message buffer slots, one in-use bit per slot. A client asks for a slot and tags the request as receive or transmit. The block answers one cycle later with a slot index and a grant pulse, or with a failure pulse when no slot is available. A separate release port returns a slot to the pool. The payload storage itself lives elsewhere; only ownership of slots is tracked here.

The pool is split into two regions. The bottom quarter is kept for receive traffic. Transmit requests can only take slots from the upper three quarters. Because of this, a backlog of outgoing messages can never use up the buffers needed to accept the replies that would drain that backlog. Receive requests may use any slot. Both kinds of request take the lowest free slot they are allowed to use. The block also reports, at all times, how many slots are free in each region.

Top module: `slot_alloc`

## Requirements
- R1: While reset is asserted, and after it is released, every slot is free, `grant_vld`, `grant_fail` and `grant_idx` are zero, `rx_free_cnt` equals POOL_SIZE/4 and `tx_free_cnt` equals 3*POOL_SIZE/4.
- R2: A request with `alloc_cat`=0 (receive) is granted the lowest-numbered free slot anywhere in the pool.
- R3: A request with `alloc_cat`=1 (transmit) is granted the lowest-numbered free slot whose index is at least POOL_SIZE/4. It is never granted a slot below that index.
- R4: A granted slot stays in use until it is released, so no slot is granted twice without a release in between.
- R5: When no eligible slot is free, the response cycle shows `grant_fail`=1, `grant_vld`=0 and `grant_idx`=0, and no slot changes state.
- R6: A release of a slot clears that slot's in-use bit whether or not the bit was set. Releasing a slot that is already free has no other effect.
- R7: When a release and an allocation arrive in the same cycle, the slot being released cannot be granted in that cycle. It can be granted from the next cycle on.
- R8: The result of a request sampled at clock edge N appears on the outputs after edge N and lasts exactly one cycle. When there is no request, both `grant_vld` and `grant_fail` are 0 in the following cycle.
- R9: `rx_free_cnt` and `tx_free_cnt` give the number of free slots in the receive-only region (indices below POOL_SIZE/4) and in the shared region, as they stand after the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocation request, sampled each rising edge |
| alloc_cat | input | 1 | Request category: 0 receive, 1 transmit |
| free_req | input | 1 | Release request |
| free_idx | input | $clog2(POOL_SIZE) | Slot to release |
| grant_vld | output | 1 | One-cycle pulse: a slot was granted |
| grant_fail | output | 1 | One-cycle pulse: no eligible slot was free |
| grant_idx | output | $clog2(POOL_SIZE) | Granted slot index, zero unless grant_vld |
| rx_free_cnt | output | $clog2(POOL_SIZE+1) | Free slots in the receive-only region |
| tx_free_cnt | output | $clog2(POOL_SIZE+1) | Free slots in the shared region |

## Verification
Requests and releases are applied at a falling edge and sampled at the next rising edge. The grant outputs and both free counts all change at that same rising edge, so each response is due exactly one edge after its stimulus. The bench reads every result 1 ns after that edge and compares it with a slot-occupancy model that it updates at the same point. The effect of a release is read on the following edge, either through the counts or through which slot the next request receives. This shows both the same-cycle exclusion and the availability of the slot from the next cycle.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic {
    CAT_RX = 1'b0,
    CAT_TX = 1'b1
  } alloc_cat_e;
endpackage

// File: rtl/slot_lowest_set.sv
module slot_lowest_set #(
  parameter int WIDTH = 64,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slot_popcount.sv
module slot_popcount #(
  parameter int WIDTH = 64,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < WIDTH; i++) begin
      cnt = cnt + CNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
  import slot_alloc_pkg::*;
#(
  parameter int POOL_SIZE = 64,
  localparam int IDX_W = $clog2(POOL_SIZE),
  localparam int CNT_W = $clog2(POOL_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             alloc_cat,
  input  logic             free_req,
  input  logic [IDX_W-1:0] free_idx,
  output logic             grant_vld,
  output logic             grant_fail,
  output logic [IDX_W-1:0] grant_idx,
  output logic [CNT_W-1:0] rx_free_cnt,
  output logic [CNT_W-1:0] tx_free_cnt
);
  localparam int RSV = POOL_SIZE / 4;
  localparam logic [POOL_SIZE-1:0] RX_ONLY = {{(POOL_SIZE-RSV){1'b0}}, {RSV{1'b1}}};
  localparam logic [POOL_SIZE-1:0] SHARED  = ~RX_ONLY;

  if ((POOL_SIZE % 4) != 0 || POOL_SIZE < 4) begin : g_bad_size
    $error("POOL_SIZE must be a positive multiple of 4");
  end

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic [POOL_SIZE-1:0] used_q, used_d;
  logic [POOL_SIZE-1:0] free_oh, grant_oh, eligible;
  logic                 enc_found;
  logic [IDX_W-1:0]     enc_idx;
  logic                 vld_d, fail_d;
  logic [IDX_W-1:0]     idx_d;
  logic                 state_en;

  always_comb begin
    free_oh = '0;
    if (free_req) free_oh[free_idx] = 1'b1;
  end

  // a slot being released this cycle is never a candidate (release wins)
  always_comb begin
    eligible = ~used_q & ~free_oh;
    if (alloc_cat_e'(alloc_cat) == CAT_TX) eligible = eligible & SHARED;
  end

  slot_lowest_set #(.WIDTH(POOL_SIZE)) u_pick (
    .vec   (eligible),
    .found (enc_found),
    .idx   (enc_idx)
  );

  always_comb begin
    grant_oh = '0;
    vld_d    = 1'b0;
    fail_d   = 1'b0;
    idx_d    = '0;
    if (alloc_req) begin
      if (enc_found) begin
        vld_d             = 1'b1;
        idx_d             = enc_idx;
        grant_oh[enc_idx] = 1'b1;
      end else begin
        fail_d = 1'b1;
      end
    end
    used_d   = (used_q & ~free_oh) | grant_oh;
    state_en = alloc_req | free_req;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      used_q <= '0;
    end else if (state_en) begin
      used_q <= used_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      grant_vld  <= 1'b0;
      grant_fail <= 1'b0;
      grant_idx  <= '0;
    end else begin
      grant_vld  <= vld_d;
      grant_fail <= fail_d;
      grant_idx  <= idx_d;
    end
  end

  slot_popcount #(.WIDTH(POOL_SIZE)) u_cnt_rx (
    .vec (~used_q & RX_ONLY),
    .cnt (rx_free_cnt)
  );

  slot_popcount #(.WIDTH(POOL_SIZE)) u_cnt_tx (
    .vec (~used_q & SHARED),
    .cnt (tx_free_cnt)
  );

  AST_GRANT_XOR_FAIL: assert property (@(posedge clk) disable iff (!srst_n)
    !(grant_vld && grant_fail)); // R5
  AST_FAIL_IDX_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    grant_fail |-> grant_idx == '0); // R5
  AST_ONE_CYCLE_RESP: assert property (@(posedge clk) disable iff (!srst_n)
    !alloc_req |=> !grant_vld && !grant_fail); // R8
  AST_TX_ABOVE_RSV: assert property (@(posedge clk) disable iff (!srst_n)
    alloc_req && alloc_cat |=> grant_fail || (int'(grant_idx) >= RSV)); // R3
  AST_GRANTED_HELD: assert property (@(posedge clk) disable iff (!srst_n)
    grant_vld |-> used_q[grant_idx]); // R4
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    free_req |=> !used_q[$past(free_idx)]); // R6
  AST_FREED_NOT_GRANTED: assert property (@(posedge clk) disable iff (!srst_n)
    free_req && alloc_req |=> !(grant_vld && grant_idx == $past(free_idx))); // R7
  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!srst_n)
    int'(rx_free_cnt) + int'(tx_free_cnt) == POOL_SIZE - $countones(used_q)); // R9
endmodule

// File: tb/sim_slot_alloc.sv
module sim_slot_alloc;
  localparam int N   = 8;
  localparam int Q   = N / 4;
  localparam int IW  = $clog2(N);
  localparam int CW  = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_req, alloc_cat, free_req;
  logic [IW-1:0] free_idx;
  logic          grant_vld, grant_fail;
  logic [IW-1:0] grant_idx;
  logic [CW-1:0] rx_free_cnt, tx_free_cnt;

  int checks = 0;
  int errors = 0;
  bit mdl [N];

  always #2 clk = ~clk;

  slot_alloc #(.POOL_SIZE(N)) u0 (
    .clk, .rst_n, .alloc_req, .alloc_cat, .free_req, .free_idx,
    .grant_vld, .grant_fail, .grant_idx, .rx_free_cnt, .tx_free_cnt
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_counts(input string tag);
    int er = 0;
    int et = 0;
    for (int i = 0; i < N; i++) begin
      if (!mdl[i]) begin
        if (i < Q) er++;
        else       et++;
      end
    end
    chk(int'(rx_free_cnt) == er, tag, "rx_free_cnt", int'(rx_free_cnt), er);
    chk(int'(tx_free_cnt) == et, tag, "tx_free_cnt", int'(tx_free_cnt), et);
  endtask

  task automatic cyc(input bit req, input bit cat, input bit fr, input int fidx,
                     input string tag);
    int exp_idx = -1;
    int start;
    @(negedge clk);
    alloc_req = req;
    alloc_cat = cat;
    free_req  = fr;
    free_idx  = IW'(fidx);
    start = cat ? Q : 0;
    for (int i = N - 1; i >= start; i--) begin
      if (!mdl[i] && !(fr && i == fidx)) exp_idx = i;
    end
    @(posedge clk);
    #1;
    if (fr) mdl[fidx] = 1'b0;
    if (req && exp_idx >= 0) mdl[exp_idx] = 1'b1;
    if (req && exp_idx >= 0) begin
      chk(grant_vld == 1'b1, tag, "grant_vld", int'(grant_vld), 1);
      chk(grant_fail == 1'b0, tag, "grant_fail", int'(grant_fail), 0);
      chk(int'(grant_idx) == exp_idx, tag, "grant_idx", int'(grant_idx), exp_idx);
    end else if (req) begin
      chk(grant_vld == 1'b0, tag, "grant_vld on fail", int'(grant_vld), 0);
      chk(grant_fail == 1'b1, tag, "grant_fail", int'(grant_fail), 1);
      chk(grant_idx == '0, tag, "grant_idx on fail", int'(grant_idx), 0);
    end else begin
      chk(!grant_vld && !grant_fail, tag, "idle pulse", int'({grant_vld, grant_fail}), 0);
    end
    chk_counts(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 200000 expected fewer cycles");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    alloc_req = 1'b0;
    alloc_cat = 1'b0;
    free_req  = 1'b0;
    free_idx  = '0;
    rst_n     = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!grant_vld && !grant_fail && grant_idx == '0, "R1", "outputs in reset",
        int'({grant_vld, grant_fail, grant_idx}), 0);
    chk_counts("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!grant_vld && !grant_fail, "R1", "outputs after reset",
        int'({grant_vld, grant_fail}), 0);
    chk(int'(rx_free_cnt) == Q, "R1", "rx_free_cnt", int'(rx_free_cnt), Q);
    chk(int'(tx_free_cnt) == N - Q, "R1", "tx_free_cnt", int'(tx_free_cnt), N - Q);

    // transmit fills shared region from index Q upward, then fails
    for (int k = 0; k < N - Q; k++) cyc(1, 1, 0, 0, "R3");
    cyc(1, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, "R8");
    // receive takes the reserved slots, then fails
    for (int k = 0; k < Q; k++) cyc(1, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, "R9");
    // release then reuse
    cyc(0, 0, 1, 5, "R6");
    cyc(1, 1, 0, 0, "R4");
    cyc(0, 0, 1, 4, "R6");
    cyc(0, 0, 1, 4, "R6");
    // receive may use a shared slot when its own region is full
    cyc(1, 0, 0, 0, "R2");
    cyc(0, 0, 1, 4, "R6");
    // same-cycle release and request
    cyc(1, 0, 1, 1, "R7");
    cyc(1, 0, 0, 0, "R7");
    cyc(1, 1, 1, 4, "R7");
    cyc(1, 1, 0, 0, "R7");

    // long pseudo-random sweep against the occupancy model
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[5], lfsr[1], lfsr[2] & lfsr[7], int'(lfsr[11:9]) % N, "R4");
    end
    cyc(0, 0, 0, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule